// File: doc/BRIEF.md
# Swap Cell Gate Pulse Sequencer

This block generates the digital timing for the gate electrodes of a swap cell, the structure that moves two spin qubits past one another. When enabled from idle, it first runs a staggered cascade on four S-gate control lines. Each line switches on in turn, one delay stage apart, and then switches off in the same order. It then drives a single A-gate line, shared by both A electrodes, with a burst. The burst is a fixed sub-pattern of a short off window followed by a long on window, repeated a set number of times. At the end it flags completion for one cycle.

Two nested counters time the burst. An inner cycle counter spans one sub-pattern, and an outer repetition counter counts the sub-patterns. With the default parameters a sub-pattern is 256 cycles: 2 off and 254 on. It repeats 24 times. Dropping enable at any point forces every output low at once, and the sequencer falls back to idle on the next edge. Analog levels, slew and conditional swapping are outside this block.

Top module: `swap_pulse_sequencer`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls with `enable` low, every output (`s_gate`, `a_gate`, `busy`, `done`) is 0.
- R2: An edge that sees `enable` high in idle starts the cascade. Right after that edge `busy` is 1 and `s_gate[0]` is 1.
- R3: The cascade runs 2·N_LINES stages of DELAY_CYCLES cycles each. In stage k < N_LINES, lines 0..k are on (bit i of `s_gate` is line i). In stage k ≥ N_LINES, only lines with index above k−N_LINES are on, so the last stage has all lines off. `a_gate` is 0 throughout.
- R4: In the burst, the cycle counter c runs over 0..2^CYC_W−1. `a_gate` is 0 for c < OFF_CYCLES and 1 otherwise. `s_gate` is all zero.
- R5: The burst is exactly REPS sub-patterns long. The cycle after the last one is the completion cycle.
- R6: In the completion cycle, `done` is 1 for exactly one cycle, and `busy`, `a_gate` and `s_gate` are 0. `busy` is 1 in every cascade and burst cycle.
- R7: After completion, with `enable` still high, all outputs stay 0 and no new sequence starts. A new sequence needs `enable` to go low for at least one edge and then high again.
- R8: When `enable` goes low in any cycle of a sequence, all outputs are 0 in that same cycle and 0 on the next edge. A later enable restarts from cascade stage 0.
- R9: A reset pulse during a sequence clears both counters and the phase. With `enable` held high, the sequence starts again from stage 0 on the edge after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Start when high in idle; abort when low |
| s_gate | output | N_LINES | S-gate control lines, bit i drives line i |
| a_gate | output | 1 | Shared A-gate control line |
| busy | output | 1 | High through cascade and burst |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds a small instance with DELAY_CYCLES=2, CYC_W=3, OFF_CYCLES=2, REPS=3 and REP_W=2, so one full sequence takes only 41 cycles. That makes it practical to abort at every single cycle of the sequence, including the completion cycle, and to check restart after each abort. A second instance with the default parameters runs one full 24×256 burst. This covers the true counter widths, the 8-bit wrap and the 5-bit repetition count against the arithmetic model.

// File: rtl/swpseq_pkg.sv
package swpseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CASCADE,
        ST_BURST,
        ST_DONE,
        ST_PARK
    } seq_state_t;

    typedef struct packed {
        logic a_on;
        logic last;
    } burst_stat_t;

    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/swpseq_cascade.sv
module swpseq_cascade
    import swpseq_pkg::*;
#(
    parameter int N_LINES      = 4,
    parameter int DELAY_CYCLES = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    output logic [N_LINES-1:0] lines,
    output logic               last
);
    localparam int STEPS  = 2 * N_LINES;
    localparam int STEP_W = cnt_width(STEPS);
    localparam int TMR_W  = cnt_width(DELAY_CYCLES);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);
    localparam logic [STEP_W-1:0] STEP_HALF = STEP_W'(N_LINES);
    localparam logic [TMR_W-1:0]  TMR_LAST  = TMR_W'(DELAY_CYCLES - 1);

    logic [TMR_W-1:0]  tmr;
    logic [STEP_W-1:0] step;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tmr  <= '0;
            step <= '0;
        end else if (tmr == TMR_LAST) begin
            tmr  <= '0;
            step <= step + 1'b1;
        end else begin
            tmr <= tmr + 1'b1;
        end
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign lines[i] = run && ((step < STEP_HALF) ? (step >= STEP_W'(i))
                                                     : ((step - STEP_HALF) < STEP_W'(i)));
    end

    assign last = run && (step == STEP_LAST) && (tmr == TMR_LAST);

    AST_ONE_LINE_PER_STAGE: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> ($countones(lines ^ $past(lines)) <= 1)); // R3
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (tmr != '0)) |-> $stable(lines)); // R3

endmodule

// File: rtl/swpseq_burst.sv
module swpseq_burst
    import swpseq_pkg::*;
#(
    parameter int CYC_W      = 8,
    parameter int OFF_CYCLES = 2,
    parameter int REPS       = 24,
    parameter int REP_W      = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    output burst_stat_t stat
);
    localparam logic [CYC_W-1:0] CYC_MAX  = '1;
    localparam logic [CYC_W-1:0] OFF_V    = CYC_W'(OFF_CYCLES);
    localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPS - 1);

    logic [CYC_W-1:0] cyc;
    logic [REP_W-1:0] rep;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cyc <= '0;
            rep <= '0;
        end else begin
            cyc <= cyc + 1'b1;
            if (cyc == CYC_MAX) begin
                rep <= rep + 1'b1;
            end
        end
    end

    always_comb begin
        stat.a_on = run && (cyc >= OFF_V);
        stat.last = run && (cyc == CYC_MAX) && (rep == REP_LAST);
    end

    AST_REP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (rep <= REP_LAST)); // R5
    AST_REP_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (rep != $past(rep))) |-> ($past(cyc) == CYC_MAX)); // R5
    AST_OFF_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && ($past(cyc) == CYC_MAX) && (OFF_CYCLES > 0)) |-> !stat.a_on); // R4

endmodule

// File: rtl/swap_pulse_sequencer.sv
module swap_pulse_sequencer
    import swpseq_pkg::*;
#(
    parameter int N_LINES      = 4,
    parameter int DELAY_CYCLES = 1,
    parameter int CYC_W        = 8,
    parameter int OFF_CYCLES   = 2,
    parameter int REPS         = 24,
    parameter int REP_W        = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    output logic [N_LINES-1:0] s_gate,
    output logic               a_gate,
    output logic               busy,
    output logic               done
);
    seq_state_t          state, state_nx;
    logic [N_LINES-1:0]  cas_lines;
    logic                cas_last;
    burst_stat_t         bst;

    swpseq_cascade #(
        .N_LINES      (N_LINES),
        .DELAY_CYCLES (DELAY_CYCLES)
    ) u_cascade (
        .clk   (clk),
        .rst   (rst),
        .run   (state == ST_CASCADE),
        .lines (cas_lines),
        .last  (cas_last)
    );

    swpseq_burst #(
        .CYC_W      (CYC_W),
        .OFF_CYCLES (OFF_CYCLES),
        .REPS       (REPS),
        .REP_W      (REP_W)
    ) u_burst (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_BURST),
        .stat (bst)
    );

    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:    state_nx = ST_CASCADE;
                ST_CASCADE: if (cas_last) state_nx = ST_BURST;
                ST_BURST:   if (bst.last) state_nx = ST_DONE;
                ST_DONE:    state_nx = ST_PARK;
                ST_PARK:    state_nx = ST_PARK;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        s_gate = enable ? cas_lines : '0;
        a_gate = enable && bst.a_on;
        busy   = enable && ((state == ST_CASCADE) || (state == ST_BURST));
        done   = enable && (state == ST_DONE);
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!busy && !done)); // R8
    AST_PHASES_APART: assert property (@(posedge clk) disable iff (rst)
        (|s_gate) |-> !a_gate); // R4
    AST_DONE_AFTER_BURST: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy)); // R5

endmodule

// File: tb/swap_pulse_sequencer_bench.sv
`timescale 1ns/1ps
module swap_pulse_sequencer_bench;

    localparam int SD = 2, SP = 8, SOFF = 2, SREPS = 3;
    localparam int SCAS = 8 * SD, SBUR = SP * SREPS;
    localparam int DD = 1, DP = 256, DOFF = 2, DREPS = 24;
    localparam int DCAS = 8 * DD, DBUR = DP * DREPS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_s = 1'b0;
    logic en_d = 1'b0;
    logic [3:0] s_s, s_d;
    logic a_s, b_s, d_s, a_d, b_d, d_d;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    swap_pulse_sequencer #(
        .N_LINES(4), .DELAY_CYCLES(SD), .CYC_W(3), .OFF_CYCLES(SOFF), .REPS(SREPS), .REP_W(2)
    ) u_swap_pulse_sequencer (
        .clk(clk), .rst(rst), .enable(en_s),
        .s_gate(s_s), .a_gate(a_s), .busy(b_s), .done(d_s)
    );

    swap_pulse_sequencer u_swap_pulse_sequencer_dflt (
        .clk(clk), .rst(rst), .enable(en_d),
        .s_gate(s_d), .a_gate(a_d), .busy(b_d), .done(d_d)
    );

    // {s_gate[3:0], a_gate, busy, done} expected t cycles after the starting edge
    function automatic logic [6:0] exp_vec(int t, int d, int p, int off, int reps);
        int cas;
        int bur;
        logic [3:0] s;
        cas = 8 * d;
        bur = p * reps;
        s = '0;
        if (t < cas) begin
            for (int i = 0; i < 4; i++) begin
                s[i] = ((t / d) < 4) ? (i <= (t / d)) : (i > (t / d) - 4);
            end
            return {s, 1'b0, 1'b1, 1'b0};
        end else if (t < cas + bur) begin
            return {4'b0000, (((t - cas) % p) >= off), 1'b1, 1'b0};
        end else if (t == cas + bur) begin
            return 7'b0000001;
        end
        return 7'b0000000;
    endfunction

    function automatic string req_of(int t, int cas, int bur);
        if (t == 0) return "R2";
        if (t < cas) return "R3";
        if (t < cas + bur) return "R4";
        if (t == cas + bur) return "R5 R6";
        return "R7";
    endfunction

    task automatic check(string req, logic [6:0] got, logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic run_small(int from, int to);
        for (int t = from; t <= to; t++) begin
            @(posedge clk);
            @(negedge clk);
            check(req_of(t, SCAS, SBUR), {s_s, a_s, b_s, d_s}, exp_vec(t, SD, SP, SOFF, SREPS));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {s_s, a_s, b_s, d_s}, 7'b0);
        check("R1", {s_d, a_d, b_d, d_d}, 7'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {s_s, a_s, b_s, d_s}, 7'b0);
        check("R1", {s_d, a_d, b_d, d_d}, 7'b0);

        // full run, then hold enable: R2..R7
        en_s = 1'b1;
        run_small(0, SCAS + SBUR + 10);
        en_s = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7", {s_s, a_s, b_s, d_s}, 7'b0);

        // abort at every cycle of the sequence: R8
        for (int k = 1; k <= SCAS + SBUR + 1; k++) begin
            en_s = 1'b1;
            run_small(0, k - 1);
            en_s = 1'b0;
            #1;
            check("R8", {s_s, a_s, b_s, d_s}, 7'b0);
            @(posedge clk);
            @(negedge clk);
            check("R8", {s_s, a_s, b_s, d_s}, 7'b0);
        end

        // reset in the middle of a sequence: R9
        en_s = 1'b1;
        run_small(0, SCAS + 5);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9", {s_s, a_s, b_s, d_s}, 7'b0);
        rst = 1'b0;
        run_small(0, SCAS + SBUR + 2);
        en_s = 1'b0;

        // default configuration, one full sequence
        @(negedge clk);
        en_d = 1'b1;
        for (int t = 0; t <= DCAS + DBUR + 4; t++) begin
            @(posedge clk);
            @(negedge clk);
            check(req_of(t, DCAS, DBUR), {s_d, a_d, b_d, d_d}, exp_vec(t, DD, DP, DOFF, DREPS));
        end
        en_d = 1'b0;

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule